// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter

This block serializes frames for a bit-oriented synchronous link, one bit per rising edge of the transmit clock, least significant bit first. A two-bit command chooses the next character on the line: a data character from a one-byte holding register, an abort character, a flag, or the frame check sequence followed by a closing flag. The command is sampled only at the decision point one bit time before a character starts, so a character already on the line always finishes intact.

At every decision point the block says it is ready for the next command. Under DATA it raises a data request level, which a write to the holding register clears. Under the other commands it gives a one-cycle interrupt pulse; for FCS the pulse comes before the closing flag. Between five consecutive ones of data or check sequence a zero is inserted. The check sequence is the reflected 16-bit CCITT CRC (polynomial x^16+x^12+x^5+1, reflected constant 0x8408), preset to all ones at every flag or abort and sent complemented. After a frame, holding the FCS command fills the line with flags or marking ones.

The state register names the kind of character on the line: ST_IDLE (disabled, line at one), ST_MARK (a single one bit sent after enable), ST_DATA, ST_ABORT, ST_FLAG, ST_FCS (16 check bits), ST_CLOSE (closing flag) and ST_FILL (between-frame filler). Transitions: ST_IDLE to ST_MARK on enable; any state to ST_IDLE when enable is low; from ST_FCS always to ST_CLOSE; from ST_CLOSE or ST_FILL to ST_FILL while the command is FCS; otherwise to ST_DATA, ST_ABORT, ST_FLAG or ST_FCS by the command, with ST_DATA replaced by ST_ABORT on underrun.

Top module: `sync_frame_tx`

## Requirements
- R1: While tx_en is low, and from the first edge after it falls, txd is 1 and data_req, irq and underrun are 0; after reset the same holds.
- R2: The command code is 00 DATA, 01 ABORT, 10 FLAG, 11 FCS; it is sampled only at a decision point, so a change in the middle of a character takes effect only after that character has been fully sent.
- R3: ABORT sends eight ones and FLAG sends 0x7E (bit order 0,1,1,1,1,1,1,0), both without zero insertion; each such character gives one irq pulse.
- R4: DATA sends bits 0 to L-1 of the holding register, L = 5 + char_len (char_len 00 gives 5 bits, 11 gives 8).
- R5: The decision for each character is made so that readiness is visible during the last bit time before its first bit: data_req rises under DATA, irq is a one-cycle pulse under ABORT or FLAG, and under FCS irq pulses in the bit time before the closing flag.
- R6: A write on thr_wr clears data_req at the next edge.
- R7: FCS sends the complement of the CRC of all data bits since the last flag or abort (reflected 0x8408, preset 0xFFFF), 16 bits LSB first, then a closing flag; the data 31..39 ("123456789") give the sent value 0x906E.
- R8: In DATA and FCS bits, a zero is inserted after every five consecutive ones; the run continues across character boundaries, and inserted zeros are not part of the CRC.
- R9: If data_req is still pending when a DATA decision is made, an abort character is sent instead, irq pulses and underrun sets and stays set until tx_en falls.
- R10: After a closing flag, while the command stays FCS, the line is filled with flags when auto_flag is 1 and with ones when it is 0, with no irq and no data_req.
- R11: On enable, one marking 1 bit precedes the first character, and the first decision is made at the enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| cmd | input | 2 | Command: 00 DATA, 01 ABORT, 10 FLAG, 11 FCS |
| char_len | input | 2 | Data character length minus five |
| auto_flag | input | 1 | Fill with flags between frames |
| thr_wr | input | 1 | Holding register write strobe |
| thr_data | input | 8 | Holding register write data |
| txd | output | 1 | Serial data out |
| data_req | output | 1 | Holding register wants a character |
| irq | output | 1 | One-cycle readiness interrupt |
| underrun | output | 1 | Holding register was not loaded in time |

## Verification
A wrong bit counter or ones counter shows on txd within one character: a flag or data pattern shifts, a zero goes missing or appears, and every later bit of the frame is offset. A CRC error stays hidden until the check sequence, at most one frame later, where 16 bits differ from the bench's own CRC of the data. A wrong decision point moves the irq or data_req edge away from the bit before the next character, which the bench catches by recording the bit index at which each pulse appears; a wrong underrun decision shows as eight ones where data was due.

// File: rtl/sync_frame_tx_pkg.sv
package sync_frame_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_DATA,
        ST_ABORT,
        ST_FLAG,
        ST_FCS,
        ST_CLOSE,
        ST_FILL
    } tx_state_e;

    localparam logic [1:0] CMD_DATA  = 2'b00;
    localparam logic [1:0] CMD_ABORT = 2'b01;
    localparam logic [1:0] CMD_FLAG  = 2'b10;
    localparam logic [1:0] CMD_FCS   = 2'b11;

    localparam logic [7:0] FLAG_PATTERN = 8'h7E;

    // Characters whose bits take part in zero insertion.
    function automatic logic is_stuffable(tx_state_e s);
        return (s == ST_DATA) || (s == ST_FCS);
    endfunction

endpackage

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 'h8408,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_upd
);

    logic         fb;
    logic [W-1:0] stepped;

    assign fb      = din ^ crc_q[0];
    assign stepped = (crc_q >> 1) ^ (fb ? POLY : '0);
    // Value including this cycle's bit, used when the check sequence is loaded.
    assign crc_upd = shift ? stepped : crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= INIT;
        else if (clear) crc_q <= INIT;
        else            crc_q <= crc_upd;
    end

endmodule

// File: rtl/tx_char_pick.sv
module tx_char_pick
    import sync_frame_tx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int FCS_W  = 16,
    parameter int LEFT_W = 5
) (
    input  tx_state_e          end_kind,
    input  logic [1:0]         cmd,
    input  logic [1:0]         char_len,
    input  logic               auto_flag,
    input  logic               req_pending,
    input  logic [CHAR_W-1:0]  thr_eff,
    output tx_state_e          pick_kind,
    output logic [CHAR_W-1:0]  pick_pat,
    output logic [LEFT_W-1:0]  pick_len,
    output logic               pick_irq,
    output logic               pick_req,
    output logic               pick_unr
);

    localparam int MIN_LEN = CHAR_W - 3;

    always_comb begin
        pick_kind = ST_FILL;
        pick_pat  = '1;
        pick_len  = LEFT_W'(CHAR_W);
        pick_irq  = 1'b0;
        pick_req  = 1'b0;
        pick_unr  = 1'b0;
        if (end_kind == ST_FCS) begin
            pick_kind = ST_CLOSE;
            pick_pat  = FLAG_PATTERN;
            pick_irq  = 1'b1;
        end else if ((end_kind == ST_CLOSE || end_kind == ST_FILL) && cmd == CMD_FCS) begin
            pick_kind = ST_FILL;
            pick_pat  = auto_flag ? FLAG_PATTERN : '1;
        end else begin
            unique case (cmd)
                CMD_DATA: begin
                    if (req_pending) begin
                        pick_kind = ST_ABORT;
                        pick_irq  = 1'b1;
                        pick_req  = 1'b1;
                        pick_unr  = 1'b1;
                    end else begin
                        pick_kind = ST_DATA;
                        pick_pat  = thr_eff;
                        pick_len  = LEFT_W'(MIN_LEN) + LEFT_W'(char_len);
                        pick_req  = 1'b1;
                    end
                end
                CMD_ABORT: begin
                    pick_kind = ST_ABORT;
                    pick_irq  = 1'b1;
                end
                CMD_FLAG: begin
                    pick_kind = ST_FLAG;
                    pick_pat  = FLAG_PATTERN;
                    pick_irq  = 1'b1;
                end
                CMD_FCS: begin
                    pick_kind = ST_FCS;
                    pick_pat  = '0;
                    pick_len  = LEFT_W'(FCS_W);
                end
            endcase
        end
    end

endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
    import sync_frame_tx_pkg::*;
#(
    parameter int CHAR_W    = 8,
    parameter int FCS_W     = 16,
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [1:0]        cmd,
    input  logic [1:0]        char_len,
    input  logic              auto_flag,
    input  logic              thr_wr,
    input  logic [CHAR_W-1:0] thr_data,
    output logic              txd,
    output logic              data_req,
    output logic              irq,
    output logic              underrun
);

    localparam int SH_W   = (FCS_W > CHAR_W) ? FCS_W : CHAR_W;
    localparam int LEFT_W = $clog2(SH_W + 1);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    // Current character
    tx_state_e          state_q, n_state;
    logic [SH_W-1:0]    sh_q, n_sh;
    logic [LEFT_W-1:0]  left_q, n_left;
    logic [ONES_W-1:0]  ones_q, n_ones;
    logic               stuff_q, n_stuff;
    logic               final_q, final_next;
    // Decided next character
    tx_state_e          nxt_kind_q;
    logic [CHAR_W-1:0]  nxt_pat_q;
    logic [LEFT_W-1:0]  nxt_len_q;
    // Host side
    logic [CHAR_W-1:0]  thr_q;
    logic               data_req_q, irq_q, underrun_q;

    logic               bit_cur, crc_shift, crc_clear, do_latch;
    logic [FCS_W-1:0]   crc_q, crc_upd;
    tx_state_e          pick_kind;
    logic [CHAR_W-1:0]  pick_pat;
    logic [LEFT_W-1:0]  pick_len;
    logic               pick_irq, pick_req, pick_unr;

    assign bit_cur = stuff_q ? 1'b0 : sh_q[0];

    tx_fcs_crc #(.W(FCS_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .shift   (crc_shift),
        .din     (sh_q[0]),
        .crc_q   (crc_q),
        .crc_upd (crc_upd)
    );

    tx_char_pick #(.CHAR_W(CHAR_W), .FCS_W(FCS_W), .LEFT_W(LEFT_W)) u_pick (
        .end_kind    (n_state),
        .cmd         (cmd),
        .char_len    (char_len),
        .auto_flag   (auto_flag),
        .req_pending (data_req_q && !thr_wr),
        .thr_eff     (thr_wr ? thr_data : thr_q),
        .pick_kind   (pick_kind),
        .pick_pat    (pick_pat),
        .pick_len    (pick_len),
        .pick_irq    (pick_irq),
        .pick_req    (pick_req),
        .pick_unr    (pick_unr)
    );

    // Next state of the character on the line, including the load at a boundary.
    always_comb begin
        n_state   = state_q;
        n_sh      = sh_q;
        n_left    = left_q;
        n_ones    = ones_q;
        n_stuff   = stuff_q;
        crc_shift = 1'b0;
        crc_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                crc_clear = 1'b1;
                n_ones    = '0;
                n_stuff   = 1'b0;
                if (tx_en) begin
                    n_state = ST_MARK;
                    n_sh    = SH_W'(1);
                    n_left  = LEFT_W'(1);
                end
            end
            default: begin
                if (stuff_q) begin
                    n_stuff = 1'b0;
                    n_ones  = '0;
                end else begin
                    n_sh      = sh_q >> 1;
                    n_left    = left_q - 1'b1;
                    crc_shift = (state_q == ST_DATA);
                    if (is_stuffable(state_q)) begin
                        if (sh_q[0]) begin
                            n_ones  = ones_q + 1'b1;
                            n_stuff = ((ones_q + 1'b1) == ONES_W'(STUFF_RUN));
                        end else begin
                            n_ones  = '0;
                        end
                    end
                end
                if (final_q) begin
                    n_state = nxt_kind_q;
                    n_left  = nxt_len_q;
                    n_stuff = 1'b0;
                    n_sh    = (nxt_kind_q == ST_FCS) ? SH_W'(~crc_upd)
                                                     : SH_W'(nxt_pat_q);
                    if (!is_stuffable(nxt_kind_q)) begin
                        n_ones    = '0;
                        crc_clear = 1'b1;
                    end
                end
            end
        endcase
        if (!tx_en) begin
            n_state   = ST_IDLE;
            n_stuff   = 1'b0;
            n_ones    = '0;
            crc_clear = 1'b1;
        end
    end

    // Is the bit time after this edge the last one before a new character?
    always_comb begin
        if (n_state == ST_IDLE)
            final_next = 1'b0;
        else if (n_stuff)
            final_next = (n_left == '0);
        else
            final_next = (n_left == LEFT_W'(1)) &&
                         !(is_stuffable(n_state) && n_sh[0] &&
                           n_ones == ONES_W'(STUFF_RUN - 1));
    end

    assign do_latch = final_next;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sh_q       <= '0;
            left_q     <= '0;
            ones_q     <= '0;
            stuff_q    <= 1'b0;
            final_q    <= 1'b0;
            nxt_kind_q <= ST_IDLE;
            nxt_pat_q  <= '0;
            nxt_len_q  <= '0;
        end else begin
            state_q <= n_state;
            sh_q    <= n_sh;
            left_q  <= n_left;
            ones_q  <= n_ones;
            stuff_q <= n_stuff;
            final_q <= final_next;
            if (do_latch) begin
                nxt_kind_q <= pick_kind;
                nxt_pat_q  <= pick_pat;
                nxt_len_q  <= pick_len;
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q      <= '0;
            data_req_q <= 1'b0;
            irq_q      <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            if (thr_wr) thr_q <= thr_data;
            irq_q <= do_latch && pick_irq;
            if (!tx_en) begin
                data_req_q <= 1'b0;
                underrun_q <= 1'b0;
            end else begin
                if (do_latch)    data_req_q <= pick_req;
                else if (thr_wr) data_req_q <= 1'b0;
                if (do_latch && pick_unr) underrun_q <= 1'b1;
            end
        end
    end

    assign txd      = (state_q == ST_IDLE) ? 1'b1 : bit_cur;
    assign data_req = data_req_q;
    assign irq      = irq_q;
    assign underrun = underrun_q;

    // Assertions
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && !data_req && !irq && !underrun));

    assert_abort_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |-> txd);

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && tx_en && !do_latch) |=> !data_req);

    assert_run_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stuffable(state_q) && ones_q == ONES_W'(STUFF_RUN)) |-> !txd);

    assert_underrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && tx_en) |=> underrun);

endmodule

// File: tb/sync_frame_tx_bench.sv
module sync_frame_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // [37:6] characters (byte k at [6+8k +: 8]), [5:3] count, [2:1] length code, [0] auto flag
    localparam logic [37:0] TV [NVEC] = '{
        {32'h0000_C35A, 3'd2, 2'd3, 1'b0},
        {32'hFFFF_FFFF, 3'd4, 2'd3, 1'b1},
        {32'h1F0F_1F1F, 3'd4, 2'd0, 1'b0},
        {32'h3E7F_016B, 3'd3, 2'd1, 1'b1},
        {32'h0055_AA7E, 3'd4, 2'd2, 1'b0},
        {32'h0000_0081, 3'd1, 2'd3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n, tx_en, auto_flag, thr_wr;
    logic [1:0] cmd, char_len;
    logic [7:0] thr_data;
    logic       txd, data_req, irq, underrun;

    int checks = 0;
    int fails  = 0;

    logic [7:0] fr_chars [16];
    int         fr_n;
    logic [1:0] fr_len;
    logic       fr_af;
    logic       exp_bits [600];
    int         exp_n;
    int         close_idx;
    logic [15:0] fcs_model;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_frame_tx u_sync_frame_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cmd(cmd), .char_len(char_len),
        .auto_flag(auto_flag), .thr_wr(thr_wr), .thr_data(thr_data),
        .txd(txd), .data_req(data_req), .irq(irq), .underrun(underrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_flag();
        for (int b = 0; b < 8; b++) push(b != 0 && b != 7);
    endtask

    // Expected line bits from the requirements
    task automatic build_exp();
        int          ones;
        logic [15:0] crc;
        logic        bitv, fb;
        int          len;
        exp_n = 0;
        push(1'b1);                       // R11 mark bit
        push_flag();
        ones = 0;
        crc  = 16'hFFFF;
        len  = 5 + int'(fr_len);
        for (int c = 0; c < fr_n; c++) begin
            for (int b = 0; b < len; b++) begin
                bitv = fr_chars[c][b];
                push(bitv);
                fb  = bitv ^ crc[0];
                crc = (crc >> 1) ^ (fb ? 16'h8408 : 16'h0000);
                ones = bitv ? ones + 1 : 0;
                if (ones == 5) begin push(1'b0); ones = 0; end
            end
        end
        fcs_model = ~crc;
        for (int b = 0; b < 16; b++) begin
            bitv = fcs_model[b];
            push(bitv);
            ones = bitv ? ones + 1 : 0;
            if (ones == 5) begin push(1'b0); ones = 0; end
        end
        close_idx = exp_n;
        push_flag();
        for (int b = 0; b < 8; b++) push(fr_af ? (b != 0 && b != 7) : 1'b1);
    endtask

    task automatic run_frame(input string name);
        int   idx, mism, first_bad, irqs, first_irq, close_irq, next_ch, req_chk, req_bad;
        bit   prev_req, last_wr;
        int   phase;
        build_exp();
        @(negedge clk);
        thr_data = fr_chars[0];
        thr_wr   = 1'b1;
        @(negedge clk);
        thr_wr    = 1'b0;
        cmd       = 2'b10;
        char_len  = fr_len;
        auto_flag = fr_af;
        tx_en     = 1'b1;
        idx = 0; mism = 0; first_bad = -1; irqs = 0; first_irq = -1; close_irq = -1;
        next_ch = 1; req_chk = 0; req_bad = 0; prev_req = 1'b0; last_wr = 1'b0; phase = 0;
        while (idx < exp_n) begin
            @(negedge clk);
            thr_wr = 1'b0;
            if (txd !== exp_bits[idx]) begin
                mism++;
                if (first_bad < 0) first_bad = idx;
            end
            if (last_wr) begin
                req_chk++;
                if (data_req) req_bad++;
            end
            last_wr = 1'b0;
            if (irq) begin
                irqs++;
                if (phase == 0) begin
                    first_irq = idx;
                    cmd   = 2'b00;
                    phase = 1;
                end else begin
                    close_irq = idx;
                end
            end
            if (phase == 1 && data_req && !prev_req) begin
                if (next_ch < fr_n) begin
                    thr_data = fr_chars[next_ch];
                    thr_wr   = 1'b1;
                    last_wr  = 1'b1;
                    next_ch++;
                end else begin
                    cmd = 2'b11;
                end
            end
            prev_req = data_req;
            idx++;
        end
        // R4 R7 R8: serial stream with data, insertion, check sequence
        check(mism == 0, {name, " R4 R7 R8 stream mismatches at bit index"}, first_bad, -1);
        // R11 R5: first decision at the enabling edge, visible on the mark bit
        check(first_irq == 0, {name, " R11 first irq bit index"}, first_irq, 0);
        // R5: irq one bit before closing flag
        check(close_irq == close_idx - 1, {name, " R5 closing irq bit index"}, close_irq, close_idx - 1);
        // R10: no interrupts during fill
        check(irqs == 2, {name, " R10 irq count"}, irqs, 2);
        check(data_req == 1'b0, {name, " R10 data_req during fill"}, int'(data_req), 0);
        check(req_bad == 0 && req_chk == fr_n - 1, {name, " R6 data_req after writes"}, req_bad, 0);
        check(underrun == 1'b0, {name, " R9 no underrun"}, int'(underrun), 0);
        tx_en = 1'b0;
        cmd   = 2'b10;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ones_bad, irqs, mism;
        logic expb;
        rst_n = 1'b0; tx_en = 1'b0; cmd = 2'b10; char_len = 2'b11;
        auto_flag = 1'b0; thr_wr = 1'b0; thr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        check(!data_req && !irq && !underrun, "R1 flags after reset",
              int'({data_req, irq, underrun}), 0);

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 4; k++) fr_chars[k] = TV[v][6 + 8*k +: 8];
            fr_n   = int'(TV[v][5:3]);
            fr_len = TV[v][2:1];
            fr_af  = TV[v][0];
            run_frame($sformatf("vec%0d", v));
        end

        // R7 known check value on "123456789"
        for (int k = 0; k < 9; k++) fr_chars[k] = 8'h31 + 8'(k);
        fr_n = 9; fr_len = 2'b11; fr_af = 1'b1;
        run_frame("crc9");
        check(fcs_model == 16'h906E, "R7 check sequence of 123456789", int'(fcs_model), 'h906E);

        // R3 R5: repeated aborts, one irq each
        cmd = 2'b01; tx_en = 1'b1;
        ones_bad = 0; irqs = 0;
        for (int i = 0; i <= 24; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) ones_bad++;
            if (irq) irqs++;
        end
        check(ones_bad == 0, "R3 abort bits all ones", ones_bad, 0);
        check(irqs == 4, "R3 R5 irq per abort", irqs, 4);
        tx_en = 1'b0;
        @(negedge clk);

        // R2: command change mid-flag does not cut the flag
        cmd = 2'b10; tx_en = 1'b1; mism = 0;
        for (int i = 0; i <= 16; i++) begin
            @(negedge clk);
            if (i == 3) cmd = 2'b01;
            if (i == 0)      expb = 1'b1;
            else if (i <= 8) expb = (i != 1 && i != 8);
            else             expb = 1'b1;
            if (txd !== expb) mism++;
        end
        check(mism == 0, "R2 flag completes before abort", mism, 0);
        tx_en = 1'b0;
        @(negedge clk);

        // R9 underrun: data_req left pending
        thr_data = 8'h00; thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0; cmd = 2'b10; char_len = 2'b11; tx_en = 1'b1;
        mism = 0; irqs = 0;
        for (int i = 0; i <= 30; i++) begin
            @(negedge clk);
            if (i == 0 && irq) cmd = 2'b00;
            if (i == 16 && irq) irqs++;
            if (i <= 24) begin
                if (i == 0)       expb = 1'b1;
                else if (i <= 8)  expb = (i != 1 && i != 8);
                else if (i <= 16) expb = 1'b0;
                else              expb = 1'b1;
                if (txd !== expb) mism++;
            end
        end
        check(mism == 0, "R9 abort replaces missing data", mism, 0);
        check(irqs == 1, "R9 irq at underrun decision", irqs, 1);
        check(underrun == 1'b1, "R9 underrun held", int'(underrun), 1);
        tx_en = 1'b0;
        @(negedge clk);
        // R1: disable returns to quiet line
        check(txd == 1'b1 && !underrun && !data_req && !irq, "R1 after disable",
              int'({txd, underrun, data_req, irq}), 8);
        @(negedge clk);
        check(txd == 1'b1, "R1 line idle while disabled", int'(txd), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule